// File: doc/BRIEF.md
# Amplifier Power and Protection Sequencer

This block is the control state machine that decides when the audio amplifiers of a mixed-signal subsystem are powered, biased, muted or held off. It takes a hard-shutdown pin, a soft-shutdown configuration bit, a mute bit, a digitised die temperature, a headphone overcurrent flag and a one-microsecond tick. From these it drives enables for the speaker, headphone and receiver amplifiers, a charge-pump enable, an output-mute control, an enable for the control interface, and a one-cycle strobe that tells the register file to reload its defaults.

The block holds audio muted for an anti-pop interval each time the amplifiers come up. It shuts the device down on over-temperature and uses hysteresis before it restarts. During a headphone overcurrent it keeps the headphone driver off and re-tries it periodically. It also separates a deep shutdown, which loses configuration, from a light one, which keeps it. Current clamping on the speaker is done in the analog domain, so this block takes no speaker overcurrent input.

Top module: `amp_pwr_seq`

## Requirements
- R1: While `hw_on` is low, `spk_en`, `hp_en`, `rcv_en`, `cp_en` and `ctl_if_en` are all 0 and `out_mute` is 1. This also holds in the cycle after reset.
- R2: When the block leaves hard shutdown, `load_defaults` is 1 for exactly one cycle. That cycle is the first clock after the edge that sampled `hw_on` high. The strobe is not raised on any other transition.
- R3: With `hw_on` high and `sw_on` low (and no thermal fault), the amplifier and charge-pump enables are 0, `out_mute` is 1 and `ctl_if_en` stays 1. On return to `sw_on` high, no `load_defaults` strobe is issued.
- R4: Whenever the amplifiers turn on, `out_mute` stays 1 for `ANTIPOP_US` rising `us_tick` samples. Audio passes from the clock after the edge that samples the last of these ticks (default 30000 ticks, i.e. 30 ms).
- R5: `cp_en` is 1 exactly when the amplifiers are active, during both the anti-pop interval and normal running.
- R6: A die temperature at or above `TRIP_C` (150, unsigned degrees) disables all amplifiers and the charge pump two clocks after it is applied, with `ctl_if_en` kept at 1. A temperature of 149 has no effect.
- R7: After a thermal trip the device stays off while the temperature is above `CLEAR_C` (120). At 120 or below it restarts with a fresh anti-pop interval, two clocks after the temperature is applied.
- R8: A headphone overcurrent sampled while the headphone driver is enabled turns `hp_en` off on the next clock, while the speaker and receiver enables are unaffected. `hp_en` is then raised for a single probe cycle every `RETRY_US` ticks for as long as the flag stays high. If the flag is low in a probe cycle, `hp_en` stays on from then on.
- R9: In normal running, `out_mute` follows `mute_req` in the same cycle, and all amplifier enables stay 1.
- R10: Priority is hard shutdown, then thermal fault, then soft shutdown, then normal operation. A thermal fault still present when hard shutdown ends leaves the amplifiers off but the interface on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_on | input | 1 | Hard-shutdown pin, low = deep shutdown |
| sw_on | input | 1 | Soft-enable bit, 0 = light shutdown |
| mute_req | input | 1 | Mute all outputs, amplifiers stay biased |
| die_temp | input | TEMP_W | Die temperature, unsigned degrees C |
| hp_ovc | input | 1 | Headphone overcurrent flag |
| us_tick | input | 1 | One-cycle pulse each microsecond |
| spk_en | output | 1 | Speaker amplifier enable |
| hp_en | output | 1 | Headphone amplifier enable |
| rcv_en | output | 1 | Receiver amplifier enable |
| cp_en | output | 1 | Charge-pump enable |
| out_mute | output | 1 | Output mute control |
| ctl_if_en | output | 1 | Control interface enable |
| load_defaults | output | 1 | One-cycle strobe to reload register defaults |

## Verification
The assertions check these rules on every cycle:
- the deep-shutdown quiet state one clock after the pin falls;
- the charge pump being on whenever the headphone driver is;
- the muted first cycle of every power-up;
- the defaults strobe following only a deep-shutdown exit;
- the thermal flag's set and hold rules;
- the single-cycle width of a headphone probe.

The exact length of the anti-pop interval, the 149/150 and 121/120 temperature boundaries, the retry period while overcurrent persists, and the priority ordering only show up in the bench's timed scenarios.

// File: rtl/amp_seq_pkg.sv
package amp_seq_pkg;

    typedef enum logic [2:0] {
        PS_HARD_OFF  = 3'd0,
        PS_THERM_OFF = 3'd1,
        PS_SOFT_OFF  = 3'd2,
        PS_WARMUP    = 3'd3,
        PS_RUN       = 3'd4
    } pwr_state_t;

    typedef enum logic [1:0] {
        HP_OK      = 2'd0,
        HP_BACKOFF = 2'd1,
        HP_PROBE   = 2'd2
    } hp_state_t;

    typedef struct packed {
        logic spk;
        logic rcv;
        logic cp;
        logic mute;
        logic iface;
    } drive_t;

    function automatic logic amps_active(pwr_state_t s);
        return (s == PS_WARMUP) || (s == PS_RUN);
    endfunction

    function automatic logic iface_active(pwr_state_t s);
        return s != PS_HARD_OFF;
    endfunction

    // Priority: pin, thermal, soft bit, then the warm-up / run progression.
    function automatic pwr_state_t pick_state(pwr_state_t cur, logic hw_on,
                                              logic hot, logic sw_on,
                                              logic warm_done);
        pwr_state_t nx;
        if (!hw_on)
            nx = PS_HARD_OFF;
        else if (hot)
            nx = PS_THERM_OFF;
        else if (!sw_on)
            nx = PS_SOFT_OFF;
        else if (cur == PS_RUN)
            nx = PS_RUN;
        else if (cur == PS_WARMUP)
            nx = warm_done ? PS_RUN : PS_WARMUP;
        else
            nx = PS_WARMUP;
        return nx;
    endfunction

endpackage

// File: rtl/amp_seq_timer.sv
module amp_seq_timer #(
    parameter int unsigned LIMIT = 30000
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic tick,
    output logic done
);
    localparam int unsigned CW = (LIMIT < 2) ? 1 : $clog2(LIMIT);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    assign done = run && tick && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || !run)
            cnt <= '0;
        else if (tick)
            cnt <= done ? '0 : cnt + 1'b1;
    end

    // R4: the interval counter never passes its last value
    p_cnt_bound_r4: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);

endmodule

// File: rtl/amp_seq_thermal.sv
module amp_seq_thermal #(
    parameter int unsigned TEMP_W  = 8,
    parameter int unsigned TRIP_C  = 150,
    parameter int unsigned CLEAR_C = 120
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [TEMP_W-1:0] die_temp,
    output logic              hot
);
    localparam logic [TEMP_W-1:0] TRIP  = TEMP_W'(TRIP_C);
    localparam logic [TEMP_W-1:0] CLEAR = TEMP_W'(CLEAR_C);

    logic at_trip;
    logic above_clear;

    assign at_trip     = die_temp >= TRIP;
    assign above_clear = die_temp > CLEAR;

    always_ff @(posedge clk) begin
        if (rst)
            hot <= 1'b0;
        else if (hot)
            hot <= above_clear;
        else
            hot <= at_trip;
    end

    p_trip_sets_r6: assert property (@(posedge clk) disable iff (rst)
        (die_temp >= TRIP) |=> hot);

    p_hyst_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (hot && die_temp > CLEAR) |=> hot);

    p_cool_stays_r6: assert property (@(posedge clk) disable iff (rst)
        (!hot && die_temp < TRIP) |=> !hot);

endmodule

// File: rtl/amp_seq_hp_retry.sv
module amp_seq_hp_retry
    import amp_seq_pkg::*;
#(
    parameter int unsigned RETRY_US = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic amps_on,
    input  logic hp_ovc,
    input  logic us_tick,
    output logic hp_gate
);
    hp_state_t st;
    hp_state_t st_n;
    logic      backoff_done;

    amp_seq_timer #(.LIMIT(RETRY_US)) u_retry_tmr (
        .clk  (clk),
        .rst  (rst),
        .run  (st == HP_BACKOFF),
        .tick (us_tick),
        .done (backoff_done)
    );

    always_comb begin
        st_n = st;
        if (!amps_on)
            st_n = HP_OK;
        else begin
            unique case (st)
                HP_OK:      if (hp_ovc) st_n = HP_BACKOFF;
                HP_BACKOFF: if (backoff_done) st_n = HP_PROBE;
                HP_PROBE:   st_n = hp_ovc ? HP_BACKOFF : HP_OK;
                default:    st_n = HP_OK;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            st <= HP_OK;
        else
            st <= st_n;
    end

    assign hp_gate = (st != HP_BACKOFF);

    // R8: overcurrent while driving closes the gate on the next clock
    p_ovc_gates_r8: assert property (@(posedge clk) disable iff (rst)
        (amps_on && hp_ovc && st == HP_OK) |=> !hp_gate);

    // R8: a probe lasts a single cycle
    p_probe_single_r8: assert property (@(posedge clk) disable iff (rst)
        (st == HP_PROBE) |=> (st != HP_PROBE));

endmodule

// File: rtl/amp_pwr_seq.sv
module amp_pwr_seq
    import amp_seq_pkg::*;
#(
    parameter int unsigned ANTIPOP_US = 30000,
    parameter int unsigned RETRY_US   = 100,
    parameter int unsigned TEMP_W     = 8,
    parameter int unsigned TRIP_C     = 150,
    parameter int unsigned CLEAR_C    = 120
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hw_on,
    input  logic              sw_on,
    input  logic              mute_req,
    input  logic [TEMP_W-1:0] die_temp,
    input  logic              hp_ovc,
    input  logic              us_tick,
    output logic              spk_en,
    output logic              hp_en,
    output logic              rcv_en,
    output logic              cp_en,
    output logic              out_mute,
    output logic              ctl_if_en,
    output logic              load_defaults
);
    pwr_state_t state;
    pwr_state_t state_n;
    logic       hot;
    logic       warm_done;
    logic       amps_on;
    logic       hp_gate;
    logic       ld_q;
    drive_t     drv;

    amp_seq_thermal #(
        .TEMP_W (TEMP_W),
        .TRIP_C (TRIP_C),
        .CLEAR_C(CLEAR_C)
    ) u_therm (
        .clk     (clk),
        .rst     (rst),
        .die_temp(die_temp),
        .hot     (hot)
    );

    amp_seq_timer #(.LIMIT(ANTIPOP_US)) u_antipop (
        .clk  (clk),
        .rst  (rst),
        .run  (state == PS_WARMUP),
        .tick (us_tick),
        .done (warm_done)
    );

    assign amps_on = amps_active(state);

    amp_seq_hp_retry #(.RETRY_US(RETRY_US)) u_hp (
        .clk    (clk),
        .rst    (rst),
        .amps_on(amps_on),
        .hp_ovc (hp_ovc),
        .us_tick(us_tick),
        .hp_gate(hp_gate)
    );

    assign state_n = pick_state(state, hw_on, hot, sw_on, warm_done);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= PS_HARD_OFF;
            ld_q  <= 1'b0;
        end else begin
            state <= state_n;
            ld_q  <= (state == PS_HARD_OFF) && (state_n != PS_HARD_OFF);
        end
    end

    always_comb begin
        drv.spk   = amps_on;
        drv.rcv   = amps_on;
        drv.cp    = amps_on;
        drv.iface = iface_active(state);
        drv.mute  = !((state == PS_RUN) && !mute_req);
    end

    assign spk_en        = drv.spk;
    assign rcv_en        = drv.rcv;
    assign cp_en         = drv.cp;
    assign ctl_if_en     = drv.iface;
    assign out_mute      = drv.mute;
    assign hp_en         = amps_on && hp_gate;
    assign load_defaults = ld_q;

    p_hard_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        !hw_on |=> (!ctl_if_en && !spk_en && !cp_en && !hp_en && out_mute));

    p_cp_with_hp_r5: assert property (@(posedge clk) disable iff (rst)
        hp_en |-> cp_en);

    p_powerup_muted_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(spk_en) |-> out_mute);

    p_defaults_src_r2: assert property (@(posedge clk) disable iff (rst)
        load_defaults |-> ($past(state) == PS_HARD_OFF && state != PS_HARD_OFF));

    p_defaults_single_r2: assert property (@(posedge clk) disable iff (rst)
        load_defaults |=> !load_defaults);

endmodule

// File: tb/sim_amp_pwr_seq.sv
module sim_amp_pwr_seq;
    localparam int unsigned AP = 6;
    localparam int unsigned RT = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       hw_on = 1'b0;
    logic       sw_on = 1'b1;
    logic       mute_req = 1'b0;
    logic [7:0] die_temp = 8'd25;
    logic       hp_ovc = 1'b0;
    logic       us_tick = 1'b0;
    logic spk_en, hp_en, rcv_en, cp_en, out_mute, ctl_if_en, load_defaults;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    amp_pwr_seq #(
        .ANTIPOP_US(AP),
        .RETRY_US  (RT),
        .TEMP_W    (8),
        .TRIP_C    (150),
        .CLEAR_C   (120)
    ) u0 (
        .clk(clk), .rst(rst), .hw_on(hw_on), .sw_on(sw_on),
        .mute_req(mute_req), .die_temp(die_temp), .hp_ovc(hp_ovc),
        .us_tick(us_tick), .spk_en(spk_en), .hp_en(hp_en), .rcv_en(rcv_en),
        .cp_en(cp_en), .out_mute(out_mute), .ctl_if_en(ctl_if_en),
        .load_defaults(load_defaults)
    );

    task automatic chk(input string tag, input logic got, input logic exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic tick_n(input int n);
        for (int i = 0; i < n; i++) begin
            us_tick = 1'b1;
            step();
            us_tick = 1'b0;
            step();
        end
    endtask

    task automatic t_reset();
        step();
        chk("R1 spk_en", spk_en, 1'b0);
        chk("R1 hp_en", hp_en, 1'b0);
        chk("R1 rcv_en", rcv_en, 1'b0);
        chk("R1 cp_en", cp_en, 1'b0);
        chk("R1 ctl_if_en", ctl_if_en, 1'b0);
        chk("R1 out_mute", out_mute, 1'b1);
        chk("R2 no strobe in reset", load_defaults, 1'b0);
    endtask

    task automatic t_hard_exit();
        hw_on = 1'b1;
        step();
        chk("R2 load_defaults pulse", load_defaults, 1'b1);
        chk("R2 interface on", ctl_if_en, 1'b1);
        chk("R5 cp on in warmup", cp_en, 1'b1);
        chk("R4 muted in warmup", out_mute, 1'b1);
        step();
        chk("R2 pulse one cycle", load_defaults, 1'b0);
    endtask

    task automatic t_warmup();
        tick_n(AP - 1);
        chk("R4 still muted at AP-1", out_mute, 1'b1);
        chk("R4 spk biased", spk_en, 1'b1);
        tick_n(1);
        chk("R4 audio passes", out_mute, 1'b0);
        chk("R5 cp in run", cp_en, 1'b1);
        chk("R4 hp on", hp_en, 1'b1);
    endtask

    task automatic t_mute();
        mute_req = 1'b1;
        #1;
        chk("R9 mute follows", out_mute, 1'b1);
        chk("R9 spk kept", spk_en, 1'b1);
        chk("R9 rcv kept", rcv_en, 1'b1);
        mute_req = 1'b0;
        #1;
        chk("R9 unmute", out_mute, 1'b0);
    endtask

    task automatic t_soft();
        sw_on = 1'b0;
        step();
        chk("R3 spk off", spk_en, 1'b0);
        chk("R3 cp off", cp_en, 1'b0);
        chk("R3 iface kept", ctl_if_en, 1'b1);
        chk("R3 muted", out_mute, 1'b1);
        sw_on = 1'b1;
        step();
        chk("R3 no defaults strobe", load_defaults, 1'b0);
        chk("R3 back to warmup", spk_en, 1'b1);
        chk("R4 warmup after soft", out_mute, 1'b1);
        tick_n(AP);
        chk("R4 run after soft", out_mute, 1'b0);
    endtask

    task automatic t_thermal();
        die_temp = 8'd149;
        step(); step();
        chk("R6 149 no trip", spk_en, 1'b1);
        die_temp = 8'd150;
        step();
        chk("R6 not yet off", spk_en, 1'b1);
        step();
        chk("R6 tripped spk", spk_en, 1'b0);
        chk("R6 tripped cp", cp_en, 1'b0);
        chk("R6 iface kept", ctl_if_en, 1'b1);
        die_temp = 8'd121;
        step(); step();
        chk("R7 121 still off", spk_en, 1'b0);
        die_temp = 8'd120;
        step(); step();
        chk("R7 restart", spk_en, 1'b1);
        chk("R7 fresh antipop", out_mute, 1'b1);
        tick_n(AP - 1);
        chk("R7 antipop full length", out_mute, 1'b1);
        tick_n(1);
        chk("R7 run again", out_mute, 1'b0);
    endtask

    task automatic t_hp();
        hp_ovc = 1'b1;
        step();
        chk("R8 hp off", hp_en, 1'b0);
        chk("R8 spk unaffected", spk_en, 1'b1);
        chk("R8 rcv unaffected", rcv_en, 1'b1);
        tick_n(RT - 1);
        chk("R8 off before period", hp_en, 1'b0);
        us_tick = 1'b1;
        step();
        us_tick = 1'b0;
        chk("R8 probe", hp_en, 1'b1);
        step();
        chk("R8 back off after probe", hp_en, 1'b0);
        tick_n(RT - 1);
        chk("R8 second wait", hp_en, 1'b0);
        us_tick = 1'b1;
        step();
        us_tick = 1'b0;
        chk("R8 second probe", hp_en, 1'b1);
        hp_ovc = 1'b0;
        step();
        chk("R8 recovered", hp_en, 1'b1);
        step();
        chk("R8 stays on", hp_en, 1'b1);
    endtask

    task automatic t_priority();
        sw_on = 1'b0;
        die_temp = 8'd160;
        hw_on = 1'b0;
        step();
        chk("R10 hard wins iface", ctl_if_en, 1'b0);
        chk("R10 hard wins spk", spk_en, 1'b0);
        hw_on = 1'b1;
        step();
        chk("R2 strobe on exit", load_defaults, 1'b1);
        chk("R10 thermal over run", spk_en, 1'b0);
        chk("R10 thermal iface", ctl_if_en, 1'b1);
        die_temp = 8'd25;
        step(); step();
        chk("R10 soft after thermal", spk_en, 1'b0);
        sw_on = 1'b1;
        step();
        chk("R10 normal last", spk_en, 1'b1);
        chk("R10 muted restart", out_mute, 1'b1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        t_reset();
        t_hard_exit();
        t_warmup();
        t_mute();
        t_soft();
        t_thermal();
        t_hp();
        t_priority();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule